// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a differential clock fan-out buffer may switch its outputs on. It runs from a free-running reference clock and walks through four states: power off, a settling delay, waiting for the input clock, and normal operation. The outputs are enabled only when four conditions hold together: the supply is valid, the settling delay has run out, the power-down pin is released, and the PLL reports lock to a present input clock.

The supply-valid indication is taken as synchronous to the reference clock. The power-down pin, the input-clock-valid flag and the PLL-lock flag are asynchronous, so each passes through a two-flop synchronizer before the state machine uses it. The settling delay is a cycle count derived from the reference frequency parameter, rounded up to whole cycles.

The outputs report the state number, a single output enable, and a drive mode for the differential pairs. A configuration input selects whether the pairs are parked high or held disabled while the block is still settling or waiting. Losing the input clock or lock, or asserting power-down, returns the machine to the waiting state and not to power off. Losing the supply returns it to power off from any state.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: During and right after reset, the state code is 0, the output enable is 0 and the drive mode is 0 (disabled).
- R2: While supply-valid is low the state code stays 0. At the first rising edge where it is high, the state code becomes 1.
- R3: State 1 lasts exactly SETTLE_CYC cycles, with SETTLE_CYC = ceil(REF_FREQ_KHZ * SETTLE_US / 1000). The state code then becomes 2.
- R4: State 2 moves to state 3 only when the synchronized power-down pin is released (high), the synchronized input clock is valid and the synchronized PLL lock is set. The output enable is 1 only in state 3. With no input clock the machine stays in state 2 with the enable at 0.
- R5: In state 3, any of power-down asserted, input clock lost or lock lost moves the machine to state 2. The output enable drops at that same edge.
- R6: Supply-valid low at a rising edge forces state 0, enable 0 and drive mode 0 at that edge, from any state. The settle counter is cleared, so the next power-up takes the full SETTLE_CYC again.
- R7: A change on the power-down pin, the clock-valid flag or the lock flag first affects the outputs at the third rising edge after the change. This delay comes from two synchronizer flops and the state register.
- R8: The drive mode code is 0 for disabled, 1 for driven high and 2 for toggling. It is 2 exactly in state 3. It is 1 in states 1 and 2 when the synchronized power-down pin is released and the configuration bit is 1. It is 0 otherwise. Driven high follows a power-down release within the bound of 300 us expressed in cycles.
- R9: The 2-bit state code equals the state number: 0 off, 1 settling, 2 waiting, 3 running.
- R10: With the input clock, lock and power-down release already present, the output enable rises SETTLE_CYC+2 edges after supply-valid is first applied. This is below 1 ms of reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply-valid indication, synchronous to clk_i |
| pwrdn_ni | input | 1 | Active-low power-down pin, asynchronous |
| refclk_ok_i | input | 1 | Input clock present flag, asynchronous |
| pll_lock_i | input | 1 | PLL lock flag, asynchronous |
| cfg_pd_high_i | input | 1 | 1 parks the outputs high while not running |
| out_en_o | output | 1 | Differential outputs enabled |
| drive_mode_o | output | 2 | 0 disabled, 1 driven high, 2 toggling |
| state_o | output | 2 | Current state number 0 to 3 |

## Verification
The assertions assume that supply-valid is already synchronous to the reference clock, and that the configuration bit is steady around each edge. They judge the state machine against the synchronized copies of the three asynchronous flags, not against the raw pins. The stimulus drives every input only at falling edges and changes supply-valid rarely, so complete settle delays occur during the random phase. The power-down, clock and lock flags toggle often enough to exercise every exit from the running state, including several causes arriving at once.

// File: rtl/clkbuf_seq_pkg.sv
package clkbuf_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_HIGH   = 2'd1,
        DRV_TOGGLE = 2'd2
    } drive_mode_e;

    // Whole reference cycles covering a time in microseconds, rounded up.
    function automatic int unsigned cycles_for_us(input int unsigned khz,
                                                  input int unsigned us);
        int unsigned raw;
        raw = (khz * us + 999) / 1000;
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/clkbuf_seq_sync.sv
module clkbuf_seq_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkbuf_seq_fsm.sv
module clkbuf_seq_fsm
    import clkbuf_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 2000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        supply_ok_i,
    input  logic        pd_rel_i,
    input  logic        clk_ok_i,
    input  logic        lock_i,
    input  logic        cfg_high_i,
    output seq_state_e  state_o,
    output logic        en_o,
    output drive_mode_e mode_o
);

    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e  state;
        logic [CW-1:0] cnt;
        logic        en;
        drive_mode_e mode;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      run_ok;

    assign run_ok = pd_rel_i && clk_ok_i && lock_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_OFF: begin
                r_d.cnt = '0;
                if (supply_ok_i) r_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (r_q.cnt == LAST_CNT) begin
                    r_d.state = ST_WAIT;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (run_ok) r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (!run_ok) r_d.state = ST_WAIT;
            end
            default: r_d.state = ST_OFF;
        endcase

        if (!supply_ok_i) begin
            r_d.state = ST_OFF;
            r_d.cnt   = '0;
        end

        r_d.en = (r_d.state == ST_RUN);
        if (r_d.state == ST_RUN)
            r_d.mode = DRV_TOGGLE;
        else if ((r_d.state == ST_SETTLE || r_d.state == ST_WAIT) && pd_rel_i && cfg_high_i)
            r_d.mode = DRV_HIGH;
        else
            r_d.mode = DRV_OFF;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_OFF;
            r_q.cnt   <= '0;
            r_q.en    <= 1'b0;
            r_q.mode  <= DRV_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign en_o    = r_q.en;
    assign mode_o  = r_q.mode;

    // R6: supply loss resets everything at the next edge
    p_supply_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> (r_q.state == ST_OFF && !r_q.en && r_q.cnt == '0 && r_q.mode == DRV_OFF));

    // R2: supply arrival starts the settle phase from a zero count
    p_off_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_OFF && supply_ok_i) |=> (r_q.state == ST_SETTLE && r_q.cnt == '0));

    // R3: the settle counter never passes its terminal value
    p_settle_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_SETTLE) |-> (r_q.cnt <= LAST_CNT));

    // R4: running is entered only with all synchronized conditions present
    p_run_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.state == ST_RUN) |-> $past(pd_rel_i && clk_ok_i && lock_i && supply_ok_i));

    // R4: no input clock keeps the enable low
    p_no_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_WAIT && !clk_ok_i) |=> !r_q.en);

    // R5: any lost condition drops back to waiting
    p_run_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN && supply_ok_i && !(pd_rel_i && clk_ok_i && lock_i))
            |=> (r_q.state == ST_WAIT && !r_q.en));

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
    import clkbuf_seq_pkg::*;
#(
    parameter int unsigned REF_FREQ_KHZ = 125000,
    parameter int unsigned SETTLE_US    = 250,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_ok_i,
    input  logic       pwrdn_ni,
    input  logic       refclk_ok_i,
    input  logic       pll_lock_i,
    input  logic       cfg_pd_high_i,
    output logic       out_en_o,
    output logic [1:0] drive_mode_o,
    output logic [1:0] state_o
);

    localparam int unsigned SETTLE_CYC = cycles_for_us(REF_FREQ_KHZ, SETTLE_US);
    localparam int unsigned NFLAG      = 3;

    logic [NFLAG-1:0] raw_flags, syn_flags;
    seq_state_e       state_w;
    drive_mode_e      mode_w;
    logic             en_w;

    assign raw_flags = {pwrdn_ni, refclk_ok_i, pll_lock_i};

    clkbuf_seq_sync #(
        .WIDTH  (NFLAG),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) flag_sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_flags),
        .q_o   (syn_flags)
    );

    clkbuf_seq_fsm #(
        .SETTLE_CYC(SETTLE_CYC)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .supply_ok_i(supply_ok_i),
        .pd_rel_i   (syn_flags[2]),
        .clk_ok_i   (syn_flags[1]),
        .lock_i     (syn_flags[0]),
        .cfg_high_i (cfg_pd_high_i),
        .state_o    (state_w),
        .en_o       (en_w),
        .mode_o     (mode_w)
    );

    assign out_en_o     = en_w;
    assign drive_mode_o = mode_w;
    assign state_o      = state_w;

    // R8: parking high needs the configuration bit at the deciding edge
    p_high_needs_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_mode_o == DRV_HIGH) |-> $past(cfg_pd_high_i));

    // R8: outputs never toggle while the enable is low
    p_toggle_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_mode_o == DRV_TOGGLE) |-> (out_en_o && state_o == 2'd3));

endmodule

// File: tb/clkbuf_pwrup_seq_tb.sv
module clkbuf_pwrup_seq_tb_top;

    localparam int unsigned FREQ_KHZ   = 8000;
    localparam int unsigned SETTLE_US  = 250;
    localparam int unsigned HIGH_US    = 300;
    localparam int unsigned SETTLE_CYC = (FREQ_KHZ * SETTLE_US + 999) / 1000;
    localparam int unsigned HIGH_CYC   = (FREQ_KHZ * HIGH_US + 999) / 1000;
    localparam int unsigned MS_CYC     = FREQ_KHZ;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok, pwrdn_n, refclk_ok, pll_lock, cfg_high;
    logic       out_en;
    logic [1:0] drive_mode, state;

    always #4 clk = ~clk;

    clkbuf_pwrup_seq #(
        .REF_FREQ_KHZ(FREQ_KHZ),
        .SETTLE_US   (SETTLE_US),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .supply_ok_i  (supply_ok),
        .pwrdn_ni     (pwrdn_n),
        .refclk_ok_i  (refclk_ok),
        .pll_lock_i   (pll_lock),
        .cfg_pd_high_i(cfg_high),
        .out_en_o     (out_en),
        .drive_mode_o (drive_mode),
        .state_o      (state)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model built from the requirements
    int       m_state, m_cnt, m_mode;
    logic     m_en;
    logic [2:0] ms1, ms2;

    function automatic int exp_mode(input int st, input logic pd_rel, input logic cfg);
        if (st == 3) return 2;
        if ((st == 1 || st == 2) && pd_rel && cfg) return 1;
        return 0;
    endfunction

    task automatic model_edge();
        int ns, nc;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_en = 1'b0; m_mode = 0;
            ms1 = '0; ms2 = '0;
            return;
        end
        ns = m_state; nc = m_cnt;
        case (m_state)
            0: begin nc = 0; if (supply_ok) ns = 1; end
            1: begin
                if (m_cnt == int'(SETTLE_CYC) - 1) begin ns = 2; nc = 0; end
                else nc = m_cnt + 1;
            end
            2: if (ms2[2] && ms2[1] && ms2[0]) ns = 3;
            default: if (!(ms2[2] && ms2[1] && ms2[0])) ns = 2;
        endcase
        if (!supply_ok) begin ns = 0; nc = 0; end
        m_state = ns; m_cnt = nc;
        m_en    = (ns == 3);
        m_mode  = exp_mode(ns, ms2[2], cfg_high);
        ms2 = ms1;
        ms1 = {pwrdn_n, refclk_ok, pll_lock};
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(int'(state) == m_state, "R9", "state code", int'(state), m_state);
        check(out_en == m_en, "R4", "output enable", int'(out_en), int'(m_en));
        check(int'(drive_mode) == m_mode, "R8", "drive mode", int'(drive_mode), m_mode);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual 150000 expected below %0d", 150000);
            summary();
            $finish;
        end
    end

    initial begin
        int t_wait, t_en, k;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; supply_ok = 1'b0; pwrdn_n = 1'b0; refclk_ok = 1'b0;
        pll_lock = 1'b0; cfg_high = 1'b0;
        repeat (3) tick();
        // R1: reset state
        check(state == 2'd0, "R1", "reset state", int'(state), 0);
        check(out_en == 1'b0, "R1", "reset enable", int'(out_en), 0);
        check(drive_mode == 2'd0, "R1", "reset drive mode", int'(drive_mode), 0);

        // R2: no supply keeps power off
        rst_n = 1'b1; pwrdn_n = 1'b1; refclk_ok = 1'b1; pll_lock = 1'b1;
        repeat (20) tick();
        check(state == 2'd0, "R2", "held off without supply", int'(state), 0);

        // R3 / R10: full power-up latency with valid inputs
        supply_ok = 1'b1;
        t_wait = -1; t_en = -1;
        for (int i = 1; i <= int'(MS_CYC); i++) begin
            tick();
            if (i == 1) check(state == 2'd1, "R2", "enter settle", int'(state), 1);
            if (t_wait < 0 && state == 2'd2) t_wait = i;
            if (out_en) begin t_en = i; break; end
        end
        check(t_wait == int'(SETTLE_CYC) + 1, "R3", "settle length", t_wait, int'(SETTLE_CYC) + 1);
        check(t_en == int'(SETTLE_CYC) + 2, "R10", "enable latency", t_en, int'(SETTLE_CYC) + 2);
        check(t_en > 0 && t_en < int'(MS_CYC), "R10", "latency below 1 ms", t_en, int'(MS_CYC));

        // R5 / R7: power-down in run
        pwrdn_n = 1'b0;
        k = 0;
        for (int i = 1; i <= 10; i++) begin tick(); if (state == 2'd2) begin k = i; break; end end
        check(k == 3, "R7", "power-down reaction edge", k, 3);
        check(out_en == 1'b0, "R5", "enable drops on power-down", int'(out_en), 0);
        pwrdn_n = 1'b1;
        k = 0;
        for (int i = 1; i <= 10; i++) begin tick(); if (state == 2'd3) begin k = i; break; end end
        check(k == 3, "R4", "re-entry to run", k, 3);

        // R5: input clock loss
        refclk_ok = 1'b0;
        k = 0;
        for (int i = 1; i <= 10; i++) begin tick(); if (state == 2'd2) begin k = i; break; end end
        check(k == 3, "R5", "clock loss returns to wait", k, 3);
        // R4: no input clock keeps outputs disabled
        repeat (3000) tick();
        check(state == 2'd2 && !out_en, "R4", "stays waiting without clock",
              int'(state), 2);

        // R8: drive-high mode after power-down release
        cfg_high = 1'b1; pwrdn_n = 1'b0;
        repeat (5) tick();
        check(drive_mode == 2'd0, "R8", "disabled during power-down", int'(drive_mode), 0);
        pwrdn_n = 1'b1;
        k = 0;
        for (int i = 1; i <= int'(HIGH_CYC); i++) begin
            tick();
            if (drive_mode == 2'd1) begin k = i; break; end
        end
        check(k == 3, "R8", "drive-high arrival edge", k, 3);
        check(k > 0 && k <= int'(HIGH_CYC), "R8", "drive-high within bound", k, int'(HIGH_CYC));

        // R6: supply loss from run and mid-settle
        refclk_ok = 1'b1;
        repeat (6) tick();
        check(state == 2'd3, "R4", "running before supply loss", int'(state), 3);
        supply_ok = 1'b0;
        tick();
        check(state == 2'd0 && !out_en && drive_mode == 2'd0, "R6", "supply loss to off",
              int'(state), 0);
        supply_ok = 1'b1;
        repeat (100) tick();
        supply_ok = 1'b0;
        tick();
        supply_ok = 1'b1;
        t_en = -1;
        for (int i = 1; i <= int'(MS_CYC); i++) begin
            tick();
            if (out_en) begin t_en = i; break; end
        end
        check(t_en == int'(SETTLE_CYC) + 2, "R6", "counter cleared on restart", t_en,
              int'(SETTLE_CYC) + 2);

        // Random phase: model compared every cycle
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(63, 0) == 0) pwrdn_n   = ~pwrdn_n;
            if ($urandom_range(63, 0) == 0) refclk_ok = ~refclk_ok;
            if ($urandom_range(63, 0) == 0) pll_lock  = ~pll_lock;
            if ($urandom_range(127, 0) == 0) cfg_high = ~cfg_high;
            if ($urandom_range(2999, 0) == 0) supply_ok = ~supply_ok;
            if (!supply_ok && $urandom_range(19, 0) == 0) supply_ok = 1'b1;
            tick();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule